// File: doc/BRIEF.md
# Hexadecimal Floating-Point Restoring Divider

This block divides one excess-64 base-16 floating-point number by another. It works in either a 32-bit single format or a 64-bit double format. Each operand is presented as a high word and a low word. The high word holds the sign, the 7-bit exponent and the top 24 fraction bits, and the low word extends the fraction in the double format. The operands are expected to be normalized or to have an all-zero fraction.

The block builds the quotient one hex digit at a time. For each digit it subtracts the divisor from the running remainder, once per clock, for as long as the remainder is not smaller than the divisor. It then shifts the remainder one digit to the left. Exponent range faults are detected before the digit loop starts, and so are a zero divisor and a zero dividend. A single-precision quotient is rounded from the final remainder, while a double-precision quotient is truncated.

The caller pulses `start` while the block is idle. It then waits for the one-cycle `done` pulse and writes the result words back to its register file when `wrEn` is high.

Top module: `hexfloat_div`

## Requirements
- R1: When the divisor fraction is zero, the block finishes with cc = 4'b1100 (C and V), keeps `wrEn` low, and leaves `resHi`/`resLo` at their previous values.
- R2: When the dividend fraction is zero and the divisor fraction is not, the result is resHi = resLo = 0 with cc = 0, whatever the signs and exponents.
- R3: If the dividend exponent minus the divisor exponent plus 64 is negative, the result is a clean zero (both words 0) with cc = 4'b0100 (V only).
- R4: Overflow happens when the exponent exceeds 127. This can occur before alignment, after the alignment increment, or after the rounding carry. On overflow, resHi = {sign, 31 ones}, resLo is all ones in double and 0 in single, and cc = V plus L (negative) or G (positive).
- R5: Single precision produces 6 quotient digits. The fraction is incremented when twice the final remainder is at least the divisor fraction. The low input words are ignored and resLo is 0.
- R6: The result exponent is the dividend exponent minus the divisor exponent plus 64, plus one when the dividend fraction is at least the divisor fraction. Results with exponent 0 or 127 are delivered as normal results.
- R7: Double precision produces 14 quotient digits with no rounding. resHi[23:0] holds the top 24 fraction bits and resLo holds the low 32.
- R8: Result layout: bit 31 is the sign, which is the XOR of the operand signs; bits 30:24 are the excess-64 exponent; bits 23:0 are the high fraction. In cc, bit 3 is C, bit 2 is V, bit 1 is G and bit 0 is L. A normal result sets L when the result is negative and G otherwise.
- R9: `busy` is high from the cycle after an accepted `start` through the `done` cycle. Early exits take 2 busy cycles. A full divide takes 3 + N + (sum of the N quotient digits) busy cycles, where N is 6 or 14.
- R10: A `start` pulse while `busy` is high is ignored, and the running divide completes with its original operands.
- R11: `done` lasts one cycle, and `wrEn` is high only in a `done` cycle.
- R12: After reset, `busy`, `done` and `wrEn` are low and resHi, resLo and cc are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a divide (accepted only when idle) |
| dblSel | input | 1 | 1 = double precision, 0 = single |
| dvdHi | input | 32 | Dividend high word |
| dvdLo | input | 32 | Dividend low fraction word |
| dvsHi | input | 32 | Divisor high word |
| dvsLo | input | 32 | Divisor low fraction word |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle completion pulse |
| wrEn | output | 1 | Result words are valid for write-back |
| resHi | output | 32 | Result high word |
| resLo | output | 32 | Result low fraction word |
| cc | output | 4 | Condition code {C, V, G, L} |

## Verification
The hardest outcome to reach is an overflow that appears only after alignment. The exponent sum is exactly 127 and passes the first range check, and the dividend fraction is at least the divisor fraction, which pushes the exponent to 128. The stimulus produces this directly with a dividend exponent of 127 and a divisor exponent of 64. A sibling case with a smaller dividend fraction shows that exponent 127 survives when no increment is applied. The latency varies with every quotient digit, so the bench model derives the expected busy length from the digits of its own wide-integer quotient. That lets it check `busy` and `done` on every clock across random operands.

// File: rtl/hfd_pkg.sv
package hfd_pkg;
  localparam int WORD_W     = 32;
  localparam int EXP_W      = 7;
  localparam int EXP_BIAS   = 64;
  localparam int HI_FRAC_W  = 24;
  localparam int LO_W       = 32;
  localparam int SGL_DIGITS = 6;
  localparam int DBL_DIGITS = 14;
  localparam int DIGIT_W    = 4;

  localparam int FRAC_W  = HI_FRAC_W + LO_W;
  localparam int REM_W   = FRAC_W + DIGIT_W;
  localparam int EXPS_W  = EXP_W + 3;
  localparam int CNT_W   = $clog2(DBL_DIGITS + 1);
  localparam int SIGN_POS = WORD_W - 1;
  localparam int EXP_MAX  = (1 << EXP_W) - 1;
  localparam int CC_W     = 4;

  localparam logic [CC_W-1:0] CC_C = 4'b1000;
  localparam logic [CC_W-1:0] CC_V = 4'b0100;
  localparam logic [CC_W-1:0] CC_G = 4'b0010;
  localparam logic [CC_W-1:0] CC_L = 4'b0001;

  typedef enum logic [2:0] {
    KIND_NORMAL,
    KIND_ZERO,
    KIND_UNDER,
    KIND_OVER,
    KIND_DZ
  } resKind_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic     load;
    logic     align;
    logic     sub;
    logic     nextDigit;
    logic     finish;
    resKind_e kind;
  } ctrlStrb_t;

  // Status from the datapath to the sequencer
  typedef struct packed {
    logic dvsZero;
    logic dvdZero;
    logic expLow;
    logic expHigh;
    logic expMax;
    logic fracGe;
    logic lastDigit;
  } dpFlags_t;
endpackage

// File: rtl/hfd_datapath.sv
module hfd_datapath
  import hfd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              dblSel,
  input  logic [WORD_W-1:0] dvdHi,
  input  logic [WORD_W-1:0] dvdLo,
  input  logic [WORD_W-1:0] dvsHi,
  input  logic [WORD_W-1:0] dvsLo,
  input  ctrlStrb_t         strb,
  output dpFlags_t          flags,
  output logic              wrEn,
  output logic [WORD_W-1:0] resHi,
  output logic [WORD_W-1:0] resLo,
  output logic [CC_W-1:0]   cc
);
  localparam logic signed [EXPS_W-1:0] BIAS_S = EXPS_W'(EXP_BIAS);
  localparam logic signed [EXPS_W-1:0] ONE_S  = EXPS_W'(1);
  localparam logic signed [EXPS_W-1:0] MAX_S  = EXPS_W'(EXP_MAX);
  localparam logic signed [EXPS_W-1:0] ZERO_S = '0;
  localparam logic [CNT_W-1:0] SGL_LAST = CNT_W'(SGL_DIGITS - 1);
  localparam logic [CNT_W-1:0] DBL_LAST = CNT_W'(DBL_DIGITS - 1);
  localparam int EXP_LSB = HI_FRAC_W;

  logic                     dblR;
  logic                     signR;
  logic signed [EXPS_W-1:0] expR;
  logic [REM_W-1:0]         remR;
  logic [REM_W-1:0]         dvsR;
  logic [FRAC_W-1:0]        quoR;
  logic [CNT_W-1:0]         cntR;

  // Operand unpacking at load time
  logic signed [EXPS_W-1:0] dvdExp, dvsExp, expStart;
  logic [REM_W-1:0]         dvdFrac, dvsFrac;

  always_comb begin
    dvdExp   = $signed({3'b000, dvdHi[SIGN_POS-1:EXP_LSB]});
    dvsExp   = $signed({3'b000, dvsHi[SIGN_POS-1:EXP_LSB]});
    expStart = dvdExp - dvsExp + BIAS_S;
    dvdFrac  = {{DIGIT_W{1'b0}}, dvdHi[HI_FRAC_W-1:0], dblSel ? dvdLo : {LO_W{1'b0}}};
    dvsFrac  = {{DIGIT_W{1'b0}}, dvsHi[HI_FRAC_W-1:0], dblSel ? dvsLo : {LO_W{1'b0}}};
  end

  // Status for the sequencer
  always_comb begin
    flags.dvsZero   = (dvsR == '0);
    flags.dvdZero   = (remR == '0);
    flags.expLow    = (expR < ZERO_S);
    flags.expHigh   = (expR > MAX_S);
    flags.expMax    = (expR == MAX_S);
    flags.fracGe    = (remR >= dvsR);
    flags.lastDigit = (cntR == (dblR ? DBL_LAST : SGL_LAST));
  end

  // Rounding and final exponent
  logic                     roundUp;
  logic [HI_FRAC_W:0]       sglSum;
  logic [HI_FRAC_W-1:0]     sglFrac;
  logic signed [EXPS_W-1:0] expFin;
  logic                     overFin;
  resKind_e                 effKind;

  always_comb begin
    roundUp = !dblR && (remR >= (dvsR << 3));
    sglSum  = {1'b0, quoR[HI_FRAC_W-1:0]} + {{HI_FRAC_W{1'b0}}, roundUp};
    if (sglSum[HI_FRAC_W]) begin
      sglFrac = sglSum[HI_FRAC_W:1] >> 3;
      expFin  = expR + ONE_S;
    end else begin
      sglFrac = sglSum[HI_FRAC_W-1:0];
      expFin  = expR;
    end
    overFin = (expFin > MAX_S);
    effKind = (strb.kind == KIND_NORMAL && overFin) ? KIND_OVER : strb.kind;
  end

  // Working registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dblR  <= 1'b0;
      signR <= 1'b0;
      expR  <= '0;
      remR  <= '0;
      dvsR  <= '0;
      quoR  <= '0;
      cntR  <= '0;
    end else if (strb.load) begin
      dblR  <= dblSel;
      signR <= dvdHi[SIGN_POS] ^ dvsHi[SIGN_POS];
      expR  <= expStart;
      remR  <= dvdFrac;
      dvsR  <= dvsFrac;
      quoR  <= '0;
      cntR  <= '0;
    end else if (strb.align) begin
      if (flags.fracGe) expR <= expR + ONE_S;
      else              remR <= remR << DIGIT_W;
    end else if (strb.sub) begin
      remR <= remR - dvsR;
      quoR <= quoR + FRAC_W'(1);
    end else if (strb.nextDigit) begin
      remR <= remR << DIGIT_W;
      cntR <= cntR + CNT_W'(1);
      if (!flags.lastDigit) quoR <= quoR << DIGIT_W;
    end
  end

  // Result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEn  <= 1'b0;
      resHi <= '0;
      resLo <= '0;
      cc    <= '0;
    end else if (strb.finish) begin
      wrEn <= (effKind != KIND_DZ);
      case (effKind)
        KIND_NORMAL: begin
          resHi <= {signR, expFin[EXP_W-1:0],
                    dblR ? quoR[FRAC_W-1:LO_W] : sglFrac};
          resLo <= dblR ? quoR[LO_W-1:0] : {LO_W{1'b0}};
          cc    <= signR ? CC_L : CC_G;
        end
        KIND_ZERO: begin
          resHi <= '0;
          resLo <= '0;
          cc    <= '0;
        end
        KIND_UNDER: begin
          resHi <= '0;
          resLo <= '0;
          cc    <= CC_V;
        end
        KIND_OVER: begin
          resHi <= {signR, {(WORD_W-1){1'b1}}};
          resLo <= dblR ? {LO_W{1'b1}} : {LO_W{1'b0}};
          cc    <= CC_V | (signR ? CC_L : CC_G);
        end
        default: begin
          cc <= CC_C | CC_V;
        end
      endcase
    end else begin
      wrEn <= 1'b0;
    end
  end
endmodule

// File: rtl/hfd_ctrl.sv
module hfd_ctrl
  import hfd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  dpFlags_t  flags,
  output ctrlStrb_t strb,
  output logic      busy,
  output logic      done
);
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RUN,
    ST_FIN,
    ST_DONE
  } state_e;

  state_e state, nxtState;

  always_comb begin
    strb     = '0;
    nxtState = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          nxtState  = ST_SETUP;
        end
      end
      ST_SETUP: begin
        strb.finish = 1'b1;
        nxtState    = ST_DONE;
        if (flags.dvsZero)                                 strb.kind = KIND_DZ;
        else if (flags.dvdZero)                            strb.kind = KIND_ZERO;
        else if (flags.expLow)                             strb.kind = KIND_UNDER;
        else if (flags.expHigh || (flags.fracGe && flags.expMax)) strb.kind = KIND_OVER;
        else begin
          strb.finish = 1'b0;
          strb.align  = 1'b1;
          nxtState    = ST_RUN;
        end
      end
      ST_RUN: begin
        if (flags.fracGe) begin
          strb.sub = 1'b1;
        end else begin
          strb.nextDigit = 1'b1;
          if (flags.lastDigit) nxtState = ST_FIN;
        end
      end
      ST_FIN: begin
        strb.finish = 1'b1;
        strb.kind   = KIND_NORMAL;
        nxtState    = ST_DONE;
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxtState;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/hexfloat_div.sv
module hexfloat_div
  import hfd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              dblSel,
  input  logic [WORD_W-1:0] dvdHi,
  input  logic [WORD_W-1:0] dvdLo,
  input  logic [WORD_W-1:0] dvsHi,
  input  logic [WORD_W-1:0] dvsLo,
  output logic              busy,
  output logic              done,
  output logic              wrEn,
  output logic [WORD_W-1:0] resHi,
  output logic [WORD_W-1:0] resLo,
  output logic [CC_W-1:0]   cc
);
  ctrlStrb_t strb;
  dpFlags_t  flags;

  hfd_ctrl ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .flags (flags),
    .strb  (strb),
    .busy  (busy),
    .done  (done)
  );

  hfd_datapath dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .dblSel (dblSel),
    .dvdHi  (dvdHi),
    .dvdLo  (dvdLo),
    .dvsHi  (dvsHi),
    .dvsLo  (dvsLo),
    .strb   (strb),
    .flags  (flags),
    .wrEn   (wrEn),
    .resHi  (resHi),
    .resLo  (resLo),
    .cc     (cc)
  );
endmodule

// File: rtl/hfd_checker.sv
module hfd_checker (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        wrEn,
  input logic [31:0] resHi,
  input logic [31:0] resLo,
  input logic [3:0]  cc
);
  p_done_in_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  p_busy_falls_after_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done));

  p_busy_needs_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  p_wren_with_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> done);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_dz_no_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    (done && cc == 4'b1100) |-> !wrEn);

  p_under_clean_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cc == 4'b0100) |-> (resHi == 32'h0 && resLo == 32'h0));

  p_over_ones_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cc[2] && (cc[1] || cc[0])) |-> (resHi[30:0] == 31'h7FFF_FFFF));

  p_normal_sign_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !cc[2] && cc[1:0] != 2'b00) |-> (cc[0] == resHi[31]));
endmodule

bind hexfloat_div hfd_checker chk_i (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .busy  (busy),
  .done  (done),
  .wrEn  (wrEn),
  .resHi (resHi),
  .resLo (resLo),
  .cc    (cc)
);

// File: tb/hexfloat_div_tb_top.sv
module hexfloat_div_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        dblSel = 1'b0;
  logic [31:0] dvdHi = '0, dvdLo = '0, dvsHi = '0, dvsLo = '0;
  logic        busy, done, wrEn;
  logic [31:0] resHi, resLo;
  logic [3:0]  cc;

  int checks = 0;
  int failures = 0;
  bit ended = 1'b0;
  logic [31:0] lastHi = '0, lastLo = '0;

  always #4 clk = ~clk;

  hexfloat_div dut_i (
    .clk(clk), .rstN(rstN), .start(start), .dblSel(dblSel),
    .dvdHi(dvdHi), .dvdLo(dvdLo), .dvsHi(dvsHi), .dvsLo(dvsLo),
    .busy(busy), .done(done), .wrEn(wrEn),
    .resHi(resHi), .resLo(resLo), .cc(cc)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Behavioural model: wide-integer long division
  task automatic refModel(input logic dbl, input logic [31:0] aHi, aLo, bHi, bLo,
                          output logic [31:0] oHi, oLo, output logic [3:0] oCc,
                          output logic oWr, output int len);
    logic [127:0] fa, fb, num, q, r;
    logic [24:0]  f;
    int e, nDig, dsum;
    logic s, ovf;
    s   = aHi[31] ^ bHi[31];
    fa  = dbl ? {72'b0, aHi[23:0], aLo} : {104'b0, aHi[23:0]};
    fb  = dbl ? {72'b0, bHi[23:0], bLo} : {104'b0, bHi[23:0]};
    e   = int'(aHi[30:24]) - int'(bHi[30:24]) + 64;
    oHi = '0; oLo = '0; oCc = '0; oWr = 1'b1; len = 2; ovf = 1'b0;
    if (fb == 0) begin
      oWr = 1'b0; oCc = 4'b1100; oHi = lastHi; oLo = lastLo;
    end else if (fa == 0) begin
      oCc = 4'b0000;
    end else if (e < 0) begin
      oCc = 4'b0100;
    end else if (e > 127) begin
      ovf = 1'b1;
    end else begin
      if (fa >= fb) e = e + 1;
      else          fa = fa << 4;
      if (e > 127) begin
        ovf = 1'b1;
      end else begin
        nDig = dbl ? 14 : 6;
        num  = fa;
        for (int k = 0; k < nDig - 1; k++) num = num << 4;
        q = num / fb;
        r = num % fb;
        dsum = 0;
        for (int k = 0; k < nDig; k++) dsum += int'(q[4*k +: 4]);
        len = dsum + nDig + 3;
        if (dbl) begin
          oHi = {s, e[6:0], q[55:32]};
          oLo = q[31:0];
        end else begin
          f = q[24:0] + ((2 * r >= fb) ? 25'd1 : 25'd0);
          if (f[24]) begin
            f = f >> 4;
            e = e + 1;
          end
          oHi = {s, e[6:0], f[23:0]};
          oLo = '0;
        end
        if (e > 127) ovf = 1'b1;
        else         oCc = s ? 4'b0001 : 4'b0010;
      end
    end
    if (ovf) begin
      oHi = {s, 31'h7FFF_FFFF};
      oLo = dbl ? 32'hFFFF_FFFF : 32'h0;
      oCc = 4'b0100 | (s ? 4'b0001 : 4'b0010);
    end
  endtask

  // Runs one divide and compares the ports with the model on every clock
  task automatic runCase(input string req, input logic dbl,
                         input logic [31:0] aHi, aLo, bHi, bLo, input bit poke);
    logic [31:0] eHi, eLo;
    logic [3:0]  eCc;
    logic        eWr;
    int          len;
    refModel(dbl, aHi, aLo, bHi, bLo, eHi, eLo, eCc, eWr, len);
    @(negedge clk);
    dblSel = dbl; dvdHi = aHi; dvdLo = aLo; dvsHi = bHi; dvsLo = bLo;
    start = 1'b1;
    for (int k = 1; k <= len + 1; k++) begin
      @(negedge clk);
      check("R9", "busy", 64'(busy), 64'(k <= len));
      check("R11", "done", 64'(done), 64'(k == len));
      check("R11", "wrEn", 64'(wrEn), 64'((k == len) && eWr));
      if (k == len) begin
        check(req, "resHi", 64'(resHi), 64'(eHi));
        check(req, "resLo", 64'(resLo), 64'(eLo));
        check(req, "cc",    64'(cc),    64'(eCc));
      end
      if (k == 1) start = 1'b0;
      if (poke && k == 2) begin
        // R10: new operands and start while busy must not disturb the run
        start = 1'b1; dblSel = ~dbl; dvdHi = 32'h7F10_0000; dvsHi = 32'h0010_0000;
      end
      if (poke && k == 3) start = 1'b0;
    end
    if (eWr) begin
      lastHi = eHi;
      lastLo = eLo;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog run did not complete");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R12", "busy",  64'(busy),  64'd0);
    check("R12", "done",  64'(done),  64'd0);
    check("R12", "wrEn",  64'(wrEn),  64'd0);
    check("R12", "resHi", 64'(resHi), 64'd0);
    check("R12", "resLo", 64'(resLo), 64'd0);
    check("R12", "cc",    64'(cc),    64'd0);

    runCase("R5",  1'b0, 32'h4110_0000, 32'h0, 32'h4110_0000, 32'h0, 1'b0);
    runCase("R5",  1'b0, 32'h4110_0000, 32'h0, 32'h4130_0000, 32'h0, 1'b0);
    runCase("R8",  1'b0, 32'hC120_0000, 32'h0, 32'h4110_0000, 32'h0, 1'b0);
    runCase("R8",  1'b0, 32'h42A5_5A5A, 32'h0, 32'hC3F0_0001, 32'h0, 1'b0);
    // R5: garbage low words in single mode have no effect
    runCase("R5",  1'b0, 32'h4112_3456, 32'hDEAD_BEEF, 32'h40FE_DCBA, 32'h1234_5678, 1'b0);
    runCase("R1",  1'b0, 32'h4110_0000, 32'h0, 32'h4100_0000, 32'h0, 1'b0);
    runCase("R1",  1'b1, 32'h4230_0000, 32'h1, 32'hC100_0000, 32'h0, 1'b0);
    runCase("R2",  1'b0, 32'h8000_0000, 32'h0, 32'h4110_0000, 32'h0, 1'b0);
    runCase("R2",  1'b1, 32'h7F00_0000, 32'h0, 32'h0010_0000, 32'h0, 1'b0);
    runCase("R3",  1'b0, 32'h0010_0000, 32'h0, 32'h7F10_0000, 32'h0, 1'b0);
    runCase("R3",  1'b1, 32'h8110_0000, 32'h0, 32'h6210_0000, 32'h0, 1'b0);
    runCase("R4",  1'b0, 32'h7F10_0000, 32'h0, 32'h3F10_0000, 32'h0, 1'b0);
    runCase("R4",  1'b1, 32'hFF40_0000, 32'h0, 32'h4020_0000, 32'h0, 1'b0);
    runCase("R4",  1'b0, 32'h7F40_0000, 32'h0, 32'h4020_0000, 32'h0, 1'b0);
    runCase("R6",  1'b0, 32'h7F20_0000, 32'h0, 32'h4040_0000, 32'h0, 1'b0);
    runCase("R6",  1'b0, 32'h0010_0000, 32'h0, 32'h4020_0000, 32'h0, 1'b0);
    runCase("R7",  1'b1, 32'h4110_0000, 32'h0, 32'h4130_0000, 32'h0, 1'b0);
    runCase("R7",  1'b1, 32'h4212_3456, 32'h789A_BCDE, 32'h41FE_DCBA, 32'h9876_5432, 1'b0);
    runCase("R7",  1'b1, 32'hC1FF_FFFF, 32'hFFFF_FFFF, 32'h4110_0000, 32'h0000_0001, 1'b0);
    runCase("R10", 1'b0, 32'h4155_5555, 32'h0, 32'h4111_1111, 32'h0, 1'b1);
    runCase("R10", 1'b1, 32'h4198_7654, 32'h3210_FEDC, 32'h4123_4567, 32'h89AB_CDEF, 1'b1);

    for (int i = 0; i < 24; i++) begin
      logic [31:0] aH, aL, bH, bL;
      logic        d;
      d  = i[0];
      aH = $urandom; aL = $urandom; bH = $urandom; bL = $urandom;
      if (aH[23:20] == 4'h0) aH[23:20] = 4'h9;
      if (bH[23:20] == 4'h0) bH[23:20] = 4'h3;
      aH[30:24] = 7'(32 + $urandom_range(0, 63));
      bH[30:24] = 7'(32 + $urandom_range(0, 63));
      runCase(d ? "R7" : "R5", d, aH, aL, bH, bL, 1'b0);
    end

    repeat (2) @(negedge clk);
    check("R11", "idle done", 64'(done), 64'd0);
    finishRun();
  end
endmodule